// File: doc/BRIEF.md
# Synchronized Glitch-Free Clock Bank Gate

This block sits after the clock synthesizer and turns banks of output clocks on and off, leaving the clock sources themselves running. There are two control groups, and each has its own asynchronous active-low stop request. The processor group drives a fast processor-rate bank and a companion mid-rate bank, and a single request controls both. The peripheral group drives a bank at the PCI rate. The stop requests come from power-management logic, which changes them just after a rising edge of the free-running PCI clock. That clock is phase-aligned with the faster clocks.

Each bank has its own synchronizer, clocked by the bank's own source clock. The synchronized enable is then retimed so that it can only change while the clock is low, and it is ANDed with the clock. A bank therefore stops only at the low level and restarts only with a complete high pulse, so it never produces a runt. Each group raises a status flag once its outputs are actually being held low. The flag drops on the rising edge of the first restarted pulse. The synchronizer depth, the output count of each bank and the enable-retiming style (falling-edge flop or low-transparent latch) are all parameters.

Top module: `clk_bank_gate`

## Requirements
- R1: While reset is asserted and just after it is released, both status flags read 0 and every bank toggles once per cycle of its source clock.
- R2: When a stop request is driven low just after a rising edge of the PCI clock, the group status stays 0 through the SYNC_STAGES-th following rising edge of the bank's source clock and reads 1 after the next one. For the processor group, that count uses the mid-rate clock.
- R3: While a group status reads 1, every output of that group is 0.
- R4: Every high pulse on any output lasts exactly half a period of its source clock. Every low interval lasts at least half a period. This holds even when a request toggles at arbitrary times.
- R5: When a stop request returns high just after a rising edge of the PCI clock, the group status stays 1 through the SYNC_STAGES-th following rising edge of the source clock. The first restarted pulse begins on the next edge, and the status reads 0 from that edge on. For the processor group, that count uses the fast clock.
- R6: The processor stop request halts both the fast bank and the mid-rate bank. While that group is stopped, neither bank shows a rising edge.
- R7: While one group is stopped, the other group's outputs rise once for every rising edge of their source clock.
- R8: After a PCI stop request, the PCI outputs rise exactly SYNC_STAGES more times and then stay low. After a PCI restart request, the outputs rise exactly once up to the edge where the status drops. So at most one rising edge separates the change of the synchronized enable from the change at the outputs.
- R9: All outputs of one bank carry the same value at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Free-running processor-rate source clock |
| clk_mid_i | input | 1 | Free-running mid-rate source clock |
| clk_pci_i | input | 1 | Free-running PCI-rate source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_stop_n | input | 1 | Asynchronous active-low stop request for the fast and mid-rate banks |
| pci_stop_n | input | 1 | Asynchronous active-low stop request for the PCI bank |
| fast_clk_o | output | N_FAST | Gated processor-rate clocks |
| mid_clk_o | output | N_MID | Gated mid-rate clocks |
| pci_clk_o | output | N_PCI | Gated PCI-rate clocks |
| fast_grp_stopped | output | 1 | Processor group held low |
| pci_grp_stopped | output | 1 | PCI group held low |

## Verification
The bench builds the block with four fast outputs, two mid-rate outputs, eight PCI outputs, a three-stage synchronizer and the falling-edge flop variant. Three stages put the status change on the fourth source edge. That makes an off-by-one in the synchronizer visible as a change one edge early or one edge late, which a two-stage build could mistake for the default. The source clocks run at ratios 1:2:4 with aligned rising edges. With that spacing, the processor group's mixed-domain status shows a different latency for stopping than for restarting, and a toggling burst of requests can land in every phase of every clock.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

   // Ways of retiming a synchronized enable so it only moves while the clock is low.
   typedef enum logic {
      GATE_NEG_FLOP = 1'b0,   // enable captured on the falling edge
      GATE_LATCH    = 1'b1    // enable passed through a latch open while clock is low
   } gate_style_e;

   localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic req_n_i,
   output logic run_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < clkgate_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("cg_sync: STAGES must be at least 2");
   end

   logic [LAST:0] ff_q;

   // Resets to all-ones: the request reads as released, so the bank runs.
   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) ff_q <= '1;
      else        ff_q <= {ff_q[LAST-1:0], req_n_i};
   end

   assign run_o = ff_q[LAST];

endmodule

// File: rtl/cg_gate_cell.sv
`timescale 1ns/1ps
module cg_gate_cell
   import clkgate_pkg::*;
#(
   parameter gate_style_e STYLE = GATE_NEG_FLOP
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic run_i,
   output logic gclk_o,
   output logic held_o
);
   logic en_q;
   logic held_q;

   if (STYLE == GATE_NEG_FLOP) begin : g_flop
      always_ff @(negedge clk_i or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b1;
         else        en_q <= run_i;
      end
   end else begin : g_latch
      always_latch begin
         if (!rst_n)      en_q = 1'b1;
         else if (!clk_i) en_q = run_i;
      end
   end

   // en_q is stable for the whole high phase, so no pulse is ever cut.
   assign gclk_o = clk_i & en_q;

   // A rising edge swallowed by the gate marks the bank as held low.
   // The first rising edge passed through marks it as running again.
   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= ~en_q;
   end

   assign held_o = held_q;

   a_r3_low_while_stopped: assert property (
      @(negedge clk_i) disable iff (!rst_n) held_q |-> !gclk_o);

   a_r5_first_pulse_full: assert property (
      @(negedge clk_i) disable iff (!rst_n) $fell(held_q) |-> gclk_o);

   a_r2_hold_after_sync: assert property (
      @(posedge clk_i) disable iff (!rst_n) $rose(held_q) |-> !$past(run_i));

   a_r5_release_after_sync: assert property (
      @(posedge clk_i) disable iff (!rst_n) $fell(held_q) |-> $past(run_i));

endmodule

// File: rtl/cg_bank.sv
`timescale 1ns/1ps
module cg_bank
   import clkgate_pkg::*;
#(
   parameter int          WIDTH  = 4,
   parameter int          STAGES = 2,
   parameter gate_style_e STYLE  = GATE_NEG_FLOP
) (
   input  logic             clk_i,
   input  logic             rst_n,
   input  logic             req_n_i,
   output logic [WIDTH-1:0] clk_o,
   output logic             held_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("cg_bank: WIDTH must be at least 1");
   end

   logic run;
   logic gclk;

   cg_sync #(.STAGES(STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_n   (rst_n),
      .req_n_i (req_n_i),
      .run_o   (run)
   );

   cg_gate_cell #(.STYLE(STYLE)) u_cell (
      .clk_i  (clk_i),
      .rst_n  (rst_n),
      .run_i  (run),
      .gclk_o (gclk),
      .held_o (held_o)
   );

   // One gated net fans out to every output, so the outputs share every edge.
   for (genvar i = 0; i < WIDTH; i++) begin : g_fan
      assign clk_o[i] = gclk;
   end

endmodule

// File: rtl/clk_bank_gate.sv
`timescale 1ns/1ps
module clk_bank_gate
   import clkgate_pkg::*;
#(
   parameter int          N_FAST      = 4,
   parameter int          N_MID       = 2,
   parameter int          N_PCI       = 8,
   parameter int          SYNC_STAGES = 2,
   parameter gate_style_e GATE_STYLE  = GATE_NEG_FLOP
) (
   input  logic              clk_fast_i,
   input  logic              clk_mid_i,
   input  logic              clk_pci_i,
   input  logic              rst_n,
   input  logic              fast_stop_n,
   input  logic              pci_stop_n,
   output logic [N_FAST-1:0] fast_clk_o,
   output logic [N_MID-1:0]  mid_clk_o,
   output logic [N_PCI-1:0]  pci_clk_o,
   output logic              fast_grp_stopped,
   output logic              pci_grp_stopped
);
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("clk_bank_gate: SYNC_STAGES must be at least 2");
   end
   if (N_FAST < 1 || N_MID < 1 || N_PCI < 1) begin : g_bad_counts
      $error("clk_bank_gate: every bank needs at least one output");
   end

   logic fast_held;
   logic mid_held;
   logic pci_held;

   cg_bank #(.WIDTH(N_FAST), .STAGES(SYNC_STAGES), .STYLE(GATE_STYLE)) u_fast (
      .clk_i   (clk_fast_i),
      .rst_n   (rst_n),
      .req_n_i (fast_stop_n),
      .clk_o   (fast_clk_o),
      .held_o  (fast_held)
   );

   // The mid-rate bank follows the processor request, retimed in its own domain.
   cg_bank #(.WIDTH(N_MID), .STAGES(SYNC_STAGES), .STYLE(GATE_STYLE)) u_mid (
      .clk_i   (clk_mid_i),
      .rst_n   (rst_n),
      .req_n_i (fast_stop_n),
      .clk_o   (mid_clk_o),
      .held_o  (mid_held)
   );

   cg_bank #(.WIDTH(N_PCI), .STAGES(SYNC_STAGES), .STYLE(GATE_STYLE)) u_pci (
      .clk_i   (clk_pci_i),
      .rst_n   (rst_n),
      .req_n_i (pci_stop_n),
      .clk_o   (pci_clk_o),
      .held_o  (pci_held)
   );

   // The processor group counts as stopped only when both of its banks are held.
   assign fast_grp_stopped = fast_held & mid_held;
   assign pci_grp_stopped  = pci_held;

   a_r6_fast_bank_low: assert property (
      @(negedge clk_fast_i) disable iff (!rst_n) fast_grp_stopped |-> (fast_clk_o == '0));

   a_r6_mid_bank_low: assert property (
      @(negedge clk_mid_i) disable iff (!rst_n) fast_grp_stopped |-> (mid_clk_o == '0));

endmodule

// File: tb/tb_clk_bank_gate.sv
`timescale 1ns/1ps
module tb_clk_bank_gate;
   localparam int  NF = 4, NM = 2, NP = 8, S = 3;
   localparam real HF = 4.0, HM = 8.0, HP = 16.0;

   logic clk_fast = 1'b0, clk_mid = 1'b0, clk_pci = 1'b0;
   logic rst_n = 1'b0, fast_stop_n = 1'b1, pci_stop_n = 1'b1;
   logic [NF-1:0] fast_o;
   logic [NM-1:0] mid_o;
   logic [NP-1:0] pci_o;
   logic fast_st, pci_st;

   clk_bank_gate #(.N_FAST(NF), .N_MID(NM), .N_PCI(NP), .SYNC_STAGES(S),
                   .GATE_STYLE(clkgate_pkg::GATE_NEG_FLOP)) dut (
      .clk_fast_i(clk_fast), .clk_mid_i(clk_mid), .clk_pci_i(clk_pci), .rst_n(rst_n),
      .fast_stop_n(fast_stop_n), .pci_stop_n(pci_stop_n),
      .fast_clk_o(fast_o), .mid_clk_o(mid_o), .pci_clk_o(pci_o),
      .fast_grp_stopped(fast_st), .pci_grp_stopped(pci_st));

   // 125 MHz fast clock; the mid and PCI clocks rise together with it at t=4.
   initial forever #4 clk_fast = ~clk_fast;
   initial begin #4; forever begin clk_mid = 1'b1; #8;  clk_mid = 1'b0; #8;  end end
   initial begin #4; forever begin clk_pci = 1'b1; #16; clk_pci = 1'b0; #16; end end

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic check_int(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Rising-edge counters for sources and outputs.
   int c_fk = 0, c_mk = 0, c_pk = 0, c_fo = 0, c_mo = 0, c_po = 0;
   always @(posedge clk_fast)  c_fk++;
   always @(posedge clk_mid)   c_mk++;
   always @(posedge clk_pci)   c_pk++;
   always @(posedge fast_o[0]) c_fo++;
   always @(posedge mid_o[0])  c_mo++;
   always @(posedge pci_o[0])  c_po++;

   // Pulse-width monitors (R4).
   int  pw_err_f = 0, pw_err_m = 0, pw_err_p = 0;
   real tr_f, tf_f, tr_m, tf_m, tr_p, tf_p;
   bit  hr_f = 0, hf_f = 0, hr_m = 0, hf_m = 0, hr_p = 0, hf_p = 0;
   always @(posedge fast_o[0]) begin
      if (hf_f && ($realtime - tf_f) < HF - 0.001) pw_err_f++;
      tr_f = $realtime; hr_f = 1;
   end
   always @(negedge fast_o[0]) begin
      if (hr_f && (($realtime - tr_f) > HF + 0.001 || ($realtime - tr_f) < HF - 0.001)) pw_err_f++;
      tf_f = $realtime; hf_f = hr_f;
   end
   always @(posedge mid_o[0]) begin
      if (hf_m && ($realtime - tf_m) < HM - 0.001) pw_err_m++;
      tr_m = $realtime; hr_m = 1;
   end
   always @(negedge mid_o[0]) begin
      if (hr_m && (($realtime - tr_m) > HM + 0.001 || ($realtime - tr_m) < HM - 0.001)) pw_err_m++;
      tf_m = $realtime; hf_m = hr_m;
   end
   always @(posedge pci_o[0]) begin
      if (hf_p && ($realtime - tf_p) < HP - 0.001) pw_err_p++;
      tr_p = $realtime; hr_p = 1;
   end
   always @(negedge pci_o[0]) begin
      if (hr_p && (($realtime - tr_p) > HP + 0.001 || ($realtime - tr_p) < HP - 0.001)) pw_err_p++;
      tf_p = $realtime; hf_p = hr_p;
   end

   // Level sampler away from all edges: stopped-low (R3) and bank uniformity (R9).
   int low_err = 0, eq_err = 0;
   initial begin
      #50.5;
      forever begin
         if (fast_st === 1'b1 && (fast_o != '0 || mid_o != '0)) low_err++;
         if (pci_st === 1'b1 && pci_o != '0) low_err++;
         if ((fast_o !== '0 && fast_o !== '1) || (mid_o !== '0 && mid_o !== '1) ||
             (pci_o !== '0 && pci_o !== '1)) eq_err++;
         #1;
      end
   end

   // Scoreboard: the driver pushes expected status changes, the monitor checks them.
   typedef struct { int grp; logic stop; } exp_t;
   exp_t sb[$];
   int   pending = 0;
   exp_t it;

   task automatic wait_edge(input int sel);
      case (sel)
         0:       @(posedge clk_fast);
         1:       @(posedge clk_mid);
         default: @(posedge clk_pci);
      endcase
   endtask

   initial begin
      forever begin
         int sel, base, st;
         wait (sb.size() != 0);
         it   = sb.pop_front();
         sel  = (it.grp == 1) ? 2 : (it.stop ? 1 : 0);
         base = c_po;
         repeat (S) wait_edge(sel);
         #1;
         st = (it.grp == 1) ? int'(pci_st) : int'(fast_st);
         check_int(it.stop ? "R2 status not yet set" : "R5 status not yet cleared", st, int'(!it.stop));
         wait_edge(sel);
         #1;
         st = (it.grp == 1) ? int'(pci_st) : int'(fast_st);
         check_int(it.stop ? "R2 status set on edge S+1" : "R5 status cleared on edge S+1", st, int'(it.stop));
         if (it.grp == 1)
            check_int(it.stop ? "R8 pci rises before hold" : "R8 pci rises to restart",
                      c_po - base, it.stop ? S : 1);
         pending--;
      end
   end

   task automatic request(input int grp, input logic stop);
      @(posedge clk_pci);
      #1;
      if (grp == 0) fast_stop_n = !stop;
      else          pci_stop_n  = !stop;
      pending++;
      sb.push_back('{grp, stop});
   endtask

   task automatic wait_idle();
      wait (pending == 0);
      #1;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      int f0, m0, p0, fk0, mk0, pk0;
      logic [15:0] lf;
      #40;
      check_int("R1 fast status in reset", int'(fast_st), 0);
      check_int("R1 pci status in reset", int'(pci_st), 0);
      #10 rst_n = 1'b1;
      #40;
      check_int("R1 fast status after reset", int'(fast_st), 0);
      f0 = c_fo; m0 = c_mo; p0 = c_po; fk0 = c_fk; mk0 = c_mk; pk0 = c_pk;
      #160;
      check_int("R1 fast bank runs", c_fo - f0, c_fk - fk0);
      check_int("R1 mid bank runs", c_mo - m0, c_mk - mk0);
      check_int("R1 pci bank runs", c_po - p0, c_pk - pk0);

      // Processor group stop, PCI keeps running.
      request(0, 1'b1);
      wait_idle();
      f0 = c_fo; m0 = c_mo; p0 = c_po; pk0 = c_pk;
      #320;
      check_int("R6 fast bank halted", c_fo - f0, 0);
      check_int("R6 mid bank halted", c_mo - m0, 0);
      check_int("R7 pci untouched", c_po - p0, c_pk - pk0);
      request(0, 1'b0);
      wait_idle();

      // PCI group stop, processor banks keep running.
      request(1, 1'b1);
      wait_idle();
      f0 = c_fo; m0 = c_mo; p0 = c_po; fk0 = c_fk; mk0 = c_mk;
      #320;
      check_int("R3 pci bank halted", c_po - p0, 0);
      check_int("R7 fast untouched", c_fo - f0, c_fk - fk0);
      check_int("R7 mid untouched", c_mo - m0, c_mk - mk0);
      request(1, 1'b0);
      wait_idle();

      // Both groups stopped together, then released in turn.
      request(0, 1'b1); wait_idle();
      request(1, 1'b1); wait_idle();
      check_int("R3 both held fast", int'(fast_st), 1);
      request(0, 1'b0); wait_idle();
      request(1, 1'b0); wait_idle();

      // A very short request pulse placed mid-cycle.
      @(posedge clk_fast); #1.5 fast_stop_n = 1'b0; #3 fast_stop_n = 1'b1;
      #200;
      check_int("R4 fast group back after short pulse", int'(fast_st), 0);

      // Asynchronous burst of toggling on both requests.
      lf = 16'hACE1;
      for (int i = 0; i < 80; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         #(real'(int'(lf % 16'd29) + 1) + 0.3);
         if (lf[0]) fast_stop_n = ~fast_stop_n;
         if (lf[1]) pci_stop_n  = ~pci_stop_n;
      end
      fast_stop_n = 1'b1; pci_stop_n = 1'b1;
      #400;
      check_int("R5 fast group resumes after burst", int'(fast_st), 0);
      check_int("R5 pci group resumes after burst", int'(pci_st), 0);
      f0 = c_fo; fk0 = c_fk;
      #80;
      check_int("R5 fast bank full rate after burst", c_fo - f0, c_fk - fk0);

      check_int("R4 fast pulse widths", pw_err_f, 0);
      check_int("R4 mid pulse widths", pw_err_m, 0);
      check_int("R4 pci pulse widths", pw_err_p, 0);
      check_int("R3 outputs low while stopped", low_err, 0);
      check_int("R9 bank outputs identical", eq_err, 0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule